// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of four oscillators drives the system clock. The four are a multi-speed internal RC, a high-speed internal RC, an external crystal oscillator and a PLL. The whole block runs on a single reference clock. Each oscillator has an enable output and a ready input. The analog oscillators, PLL locking and glitch-free clock multiplexing sit outside the block. They appear here only as ready and failure inputs.

Software writes one register-style configuration word when `cfg_we` is high. The word carries:
- the oscillator enable requests
- a 2-bit source request
- the PLL input, multiply and divide settings
- the multi-speed range
- the failure-monitor enable

A separate 2-bit status output reports the source actually in use. The status moves to a requested source only once that source reports ready. Requests to switch off an oscillator that currently feeds the system clock are refused. When the failure monitor is on and the crystal fails while it feeds the system clock, the block does the following at once:
- falls back to the multi-speed source
- turns the crystal off
- latches a failure flag, which drives a non-maskable interrupt output

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: While `rst` is high, the following hold one clock later: `osc_en` = 4'b0001 (only the multi-speed source on), `src_req` = `src_act` = 2'b00, `mon_en` = 0, `fail_flag` = 0, `nmi` = 0 and `msr_range` = 5.
- R2: Source codes are 00 multi-speed, 01 high-speed internal, 10 crystal, 11 PLL. Bit i of `osc_en`, `cfg_osc_en` and `src_rdy` belongs to source code i. A write loads `src_req` at the clock edge. `src_act` changes only to the registered `src_req` value, or to 00 on a fallback.
- R3: While `src_rdy[src_req]` is low, `src_act` holds and the request stays pending. On the first edge where that bit is high, `src_act` takes the `src_req` value.
- R4: A write that clears the crystal enable has no effect in two cases: while `src_act` is 10, and while `src_act` is 11 with `pll_in_sel` = 1 (the crystal feeds the PLL).
- R5: A write that clears the high-speed internal enable has no effect in two cases: while `src_act` is 01, and while `src_act` is 11 with `pll_in_sel` = 0 (that RC feeds the PLL).
- R6: A write that clears the multi-speed enable has no effect while `src_act` is 00. A write that clears the PLL enable has no effect while `src_act` is 11.
- R7: `pll_in_sel`, `pll_mul` and `pll_div` take new values from a write only while `src_act` is not 11.
- R8: A fallback happens on a cycle where all of the following hold:
  - `mon_en` is 1
  - `xtal_fail` is 1
  - the crystal is in use, directly or through the PLL

  On the next edge, `src_act` and `src_req` become 00, `osc_en[2]` clears, `osc_en[0]` sets, and `fail_flag` and `nmi` go high. With `mon_en` = 0, `xtal_fail` has no effect.
- R9: `fail_flag` stays set until a cycle with `fail_clr` high and no fallback. A fallback in the same cycle as `fail_clr` leaves the flag set.
- R10: A fallback cancels a pending switch. `src_req` reads 00 afterwards and the old target is not taken up when it becomes ready.
- R11: A write loads `msr_range` only when `cfg_msr_range` is 0 to 6. The range selects 32768·2^(range+1) Hz. A write with value 7 leaves `msr_range` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_osc_en | input | 4 | Requested oscillator enables, bit = source code |
| cfg_src | input | 2 | Requested system clock source |
| cfg_pll_in | input | 1 | PLL input: 0 high-speed internal, 1 crystal |
| cfg_pll_mul | input | MUL_W | PLL multiply setting |
| cfg_pll_div | input | DIV_W | PLL divide setting |
| cfg_msr_range | input | RANGE_W | Multi-speed range request |
| cfg_mon_en | input | 1 | Failure-monitor enable |
| fail_clr | input | 1 | Clears the failure flag |
| src_rdy | input | 4 | Oscillator ready flags, bit = source code |
| xtal_fail | input | 1 | Crystal failure detected |
| osc_en | output | 4 | Oscillator enables, bit = source code |
| src_req | output | 2 | Registered source request |
| src_act | output | 2 | Source actually driving the system clock |
| pll_in_sel | output | 1 | Registered PLL input select |
| pll_mul | output | MUL_W | Registered PLL multiply setting |
| pll_div | output | DIV_W | Registered PLL divide setting |
| msr_range | output | RANGE_W | Multi-speed range in force |
| mon_en | output | 1 | Failure monitor enabled |
| fail_flag | output | 1 | Sticky crystal-failure flag |
| nmi | output | 1 | Non-maskable interrupt request |

## Verification
A wrong `src_act` shows at the status port one edge after the cycle that caused it. The cause may be a switch taken before the target was ready, or a fallback that was missed. An oscillator enable that was wrongly dropped shows at `osc_en` on the edge after the write. The protection rules depend on the PLL input select, so the stimulus reaches each guarded oscillator both directly and through the PLL. A lost failure flag or a request that was not cancelled stays visible on `fail_flag`, `nmi` and `src_req` until the next write. For this reason the checks hold the bench idle for several cycles after a fallback.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        SRC_MSR  = 2'b00,
        SRC_HSR  = 2'b01,
        SRC_XTAL = 2'b10,
        SRC_PLL  = 2'b11
    } src_e;

    localparam int NSRC  = 4;
    localparam int SRC_W = 2;
    localparam logic [NSRC-1:0] EN_RST = 4'b0001;

    // Which oscillators currently feed the system clock, directly or via the PLL.
    function automatic logic [NSRC-1:0] in_use_vec(src_e act, logic pll_from_xtal);
        logic [NSRC-1:0] u;
        u = '0;
        u[SRC_MSR]  = (act == SRC_MSR);
        u[SRC_HSR]  = (act == SRC_HSR)  || ((act == SRC_PLL) && !pll_from_xtal);
        u[SRC_XTAL] = (act == SRC_XTAL) || ((act == SRC_PLL) &&  pll_from_xtal);
        u[SRC_PLL]  = (act == SRC_PLL);
        return u;
    endfunction

endpackage

// File: rtl/sclk_fail_mon.sv
module sclk_fail_mon
    import sclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_mon_en,
    input  logic fail_clr,
    input  logic xtal_fail,
    input  src_e src_act,
    input  logic pll_from_xtal,
    output logic mon_en,
    output logic fallback,
    output logic fail_flag
);

    logic xtal_used;

    always_comb begin
        xtal_used = (src_act == SRC_XTAL) || ((src_act == SRC_PLL) && pll_from_xtal);
        fallback  = mon_en && xtal_fail && xtal_used;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_en    <= 1'b0;
            fail_flag <= 1'b0;
        end else begin
            if (cfg_we)
                mon_en <= cfg_mon_en;
            if (fallback)
                fail_flag <= 1'b1;
            else if (fail_clr)
                fail_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sclk_src_switch.sv
module sclk_src_switch
    import sclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [NSRC-1:0] src_rdy,
    input  logic            fallback,
    output src_e            src_req,
    output src_e            src_act
);

    logic take;

    always_comb take = (src_req != src_act) && src_rdy[src_req];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_req <= SRC_MSR;
            src_act <= SRC_MSR;
        end else if (fallback) begin
            src_req <= SRC_MSR;
            src_act <= SRC_MSR;
        end else begin
            if (cfg_we)
                src_req <= src_e'(cfg_src);
            if (take)
                src_act <= src_req;
        end
    end

endmodule

// File: rtl/sclk_osc_regs.sv
module sclk_osc_regs
    import sclk_pkg::*;
#(
    parameter int MUL_W     = 4,
    parameter int DIV_W     = 2,
    parameter int RANGE_W   = 3,
    parameter int RANGE_MAX = 6,
    parameter int RANGE_RST = 5
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [NSRC-1:0]    cfg_osc_en,
    input  logic               cfg_pll_in,
    input  logic [MUL_W-1:0]   cfg_pll_mul,
    input  logic [DIV_W-1:0]   cfg_pll_div,
    input  logic [RANGE_W-1:0] cfg_msr_range,
    input  src_e               src_act,
    input  logic               fallback,
    output logic [NSRC-1:0]    osc_en,
    output logic               pll_from_xtal,
    output logic [MUL_W-1:0]   pll_mul,
    output logic [DIV_W-1:0]   pll_div,
    output logic [RANGE_W-1:0] msr_range
);

    localparam logic [RANGE_W-1:0] RMAX = RANGE_W'(RANGE_MAX);
    localparam logic [RANGE_W-1:0] RRST = RANGE_W'(RANGE_RST);

    logic [NSRC-1:0] in_use;

    always_comb in_use = in_use_vec(src_act, pll_from_xtal);

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)
                osc_en[i] <= EN_RST[i];
            else if (fallback && (i == int'(SRC_XTAL)))
                osc_en[i] <= 1'b0;
            else if (fallback && (i == int'(SRC_MSR)))
                osc_en[i] <= 1'b1;
            else if (cfg_we) begin
                if (cfg_osc_en[i])
                    osc_en[i] <= 1'b1;
                else if (!in_use[i])
                    osc_en[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_from_xtal <= 1'b0;
            pll_mul       <= '0;
            pll_div       <= '0;
            msr_range     <= RRST;
        end else if (cfg_we) begin
            if (src_act != SRC_PLL) begin
                pll_from_xtal <= cfg_pll_in;
                pll_mul       <= cfg_pll_mul;
                pll_div       <= cfg_pll_div;
            end
            if (cfg_msr_range <= RMAX)
                msr_range <= cfg_msr_range;
        end
    end

endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
    import sclk_pkg::*;
#(
    parameter int MUL_W     = 4,
    parameter int DIV_W     = 2,
    parameter int RANGE_W   = 3,
    parameter int RANGE_MAX = 6,
    parameter int RANGE_RST = 5
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_osc_en,
    input  logic [1:0]         cfg_src,
    input  logic               cfg_pll_in,
    input  logic [MUL_W-1:0]   cfg_pll_mul,
    input  logic [DIV_W-1:0]   cfg_pll_div,
    input  logic [RANGE_W-1:0] cfg_msr_range,
    input  logic               cfg_mon_en,
    input  logic               fail_clr,
    input  logic [3:0]         src_rdy,
    input  logic               xtal_fail,
    output logic [3:0]         osc_en,
    output logic [1:0]         src_req,
    output logic [1:0]         src_act,
    output logic               pll_in_sel,
    output logic [MUL_W-1:0]   pll_mul,
    output logic [DIV_W-1:0]   pll_div,
    output logic [RANGE_W-1:0] msr_range,
    output logic               mon_en,
    output logic               fail_flag,
    output logic               nmi
);

    src_e req_q, act_q;
    logic fallback;

    sclk_fail_mon u_mon (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_mon_en    (cfg_mon_en),
        .fail_clr      (fail_clr),
        .xtal_fail     (xtal_fail),
        .src_act       (act_q),
        .pll_from_xtal (pll_in_sel),
        .mon_en        (mon_en),
        .fallback      (fallback),
        .fail_flag     (fail_flag)
    );

    sclk_src_switch u_sw (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_src  (cfg_src),
        .src_rdy  (src_rdy),
        .fallback (fallback),
        .src_req  (req_q),
        .src_act  (act_q)
    );

    sclk_osc_regs #(
        .MUL_W     (MUL_W),
        .DIV_W     (DIV_W),
        .RANGE_W   (RANGE_W),
        .RANGE_MAX (RANGE_MAX),
        .RANGE_RST (RANGE_RST)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_osc_en    (cfg_osc_en),
        .cfg_pll_in    (cfg_pll_in),
        .cfg_pll_mul   (cfg_pll_mul),
        .cfg_pll_div   (cfg_pll_div),
        .cfg_msr_range (cfg_msr_range),
        .src_act       (act_q),
        .fallback      (fallback),
        .osc_en        (osc_en),
        .pll_from_xtal (pll_in_sel),
        .pll_mul       (pll_mul),
        .pll_div       (pll_div),
        .msr_range     (msr_range)
    );

    assign src_req = req_q;
    assign src_act = act_q;
    assign nmi     = fail_flag;

endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk #(
    parameter int MUL_W     = 4,
    parameter int DIV_W     = 2,
    parameter int RANGE_W   = 3,
    parameter int RANGE_MAX = 6
)(
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [RANGE_W-1:0] cfg_msr_range,
    input logic               fail_clr,
    input logic [3:0]         src_rdy,
    input logic               xtal_fail,
    input logic [3:0]         osc_en,
    input logic [1:0]         src_req,
    input logic [1:0]         src_act,
    input logic               pll_in_sel,
    input logic [MUL_W-1:0]   pll_mul,
    input logic [DIV_W-1:0]   pll_div,
    input logic [RANGE_W-1:0] msr_range,
    input logic               mon_en,
    input logic               fail_flag,
    input logic               nmi
);

    logic xtal_used, fb_cond;
    assign xtal_used = (src_act == 2'b10) || ((src_act == 2'b11) && pll_in_sel);
    assign fb_cond   = mon_en && xtal_fail && xtal_used;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (src_act == 2'b00 && src_req == 2'b00 && osc_en == 4'b0001 && !fail_flag && !mon_en));

    // R2
    act_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(src_act) |-> (src_act == $past(src_req) || src_act == 2'b00));

    // R3
    pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src_act != src_req && !src_rdy[src_req] && !fb_cond) |=> $stable(src_act));

    // R4
    xtal_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en[2] && xtal_used && !fb_cond) |=> osc_en[2]);

    // R5
    hsr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en[1] && (src_act == 2'b01 || (src_act == 2'b11 && !pll_in_sel))) |=> osc_en[1]);

    // R6
    msr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en[0] && src_act == 2'b00) |=> osc_en[0]);

    // R6
    pll_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en[3] && src_act == 2'b11) |=> osc_en[3]);

    // R7
    pll_cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (src_act == 2'b11) |=> ($stable(pll_in_sel) && $stable(pll_mul) && $stable(pll_div)));

    // R8
    fallback_chk: assert property (@(posedge clk) disable iff (rst)
        fb_cond |=> (src_act == 2'b00 && src_req == 2'b00 && fail_flag && nmi && !osc_en[2] && osc_en[0]));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !fail_clr) |=> fail_flag);

    // R11
    range_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_msr_range > RANGE_W'(RANGE_MAX)) |=> $stable(msr_range));

endmodule

bind sysclk_switch_ctrl sysclk_switch_chk #(
    .MUL_W     (MUL_W),
    .DIV_W     (DIV_W),
    .RANGE_W   (RANGE_W),
    .RANGE_MAX (RANGE_MAX)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_msr_range (cfg_msr_range),
    .fail_clr      (fail_clr),
    .src_rdy       (src_rdy),
    .xtal_fail     (xtal_fail),
    .osc_en        (osc_en),
    .src_req       (src_req),
    .src_act       (src_act),
    .pll_in_sel    (pll_in_sel),
    .pll_mul       (pll_mul),
    .pll_div       (pll_div),
    .msr_range     (msr_range),
    .mon_en        (mon_en),
    .fail_flag     (fail_flag),
    .nmi           (nmi)
);

// File: tb/sysclk_switch_ctrl_test.sv
module sysclk_switch_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_osc_en = 4'b0001;
    logic [1:0] cfg_src = 2'b00;
    logic       cfg_pll_in = 1'b0;
    logic [3:0] cfg_pll_mul = 4'd0;
    logic [1:0] cfg_pll_div = 2'd0;
    logic [2:0] cfg_msr_range = 3'd5;
    logic       cfg_mon_en = 1'b0;
    logic       fail_clr = 1'b0;
    logic [3:0] src_rdy = 4'b0001;
    logic       xtal_fail = 1'b0;
    logic [3:0] osc_en;
    logic [1:0] src_req, src_act;
    logic       pll_in_sel;
    logic [3:0] pll_mul;
    logic [1:0] pll_div;
    logic [2:0] msr_range;
    logic       mon_en, fail_flag, nmi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysclk_switch_ctrl uut (.*);

    // {we, en[3:0], req, pll_in, rdy[3:0], xfail, mon, clr, exp_act, exp_req, exp_en, exp_fail}
    typedef struct packed {
        logic       we;
        logic [3:0] en;
        logic [1:0] req;
        logic       pin;
        logic [3:0] rdy;
        logic       xf;
        logic       mon;
        logic       clr;
        logic [1:0] e_act;
        logic [1:0] e_req;
        logic [3:0] e_en;
        logic       e_fail;
    } vec_t;

    localparam int NV = 27;
    localparam logic [23:0] TBL [NV] = '{
        {1'b1,4'b0101,2'b10,1'b1,4'b0001,1'b0,1'b1,1'b0, 2'b00,2'b10,4'b0101,1'b0}, // R2 request crystal
        {1'b0,4'b0000,2'b00,1'b0,4'b0001,1'b0,1'b0,1'b0, 2'b00,2'b10,4'b0101,1'b0}, // R3 pending
        {1'b0,4'b0000,2'b00,1'b0,4'b0101,1'b0,1'b0,1'b0, 2'b10,2'b10,4'b0101,1'b0}, // R3 ready -> switch
        {1'b1,4'b0001,2'b10,1'b1,4'b0101,1'b0,1'b1,1'b0, 2'b10,2'b10,4'b0101,1'b0}, // R4 crystal off refused
        {1'b1,4'b1101,2'b11,1'b1,4'b0101,1'b0,1'b1,1'b0, 2'b10,2'b11,4'b1101,1'b0}, // R3 request PLL not ready
        {1'b0,4'b0000,2'b00,1'b0,4'b1101,1'b0,1'b0,1'b0, 2'b11,2'b11,4'b1101,1'b0}, // R2 PLL active
        {1'b1,4'b1001,2'b11,1'b1,4'b1101,1'b0,1'b1,1'b0, 2'b11,2'b11,4'b1101,1'b0}, // R4 via PLL refused
        {1'b1,4'b0101,2'b11,1'b1,4'b1101,1'b0,1'b1,1'b0, 2'b11,2'b11,4'b1101,1'b0}, // R6 PLL off refused
        {1'b0,4'b0000,2'b00,1'b0,4'b1101,1'b1,1'b0,1'b0, 2'b00,2'b00,4'b1001,1'b1}, // R8 fallback via PLL
        {1'b0,4'b0000,2'b00,1'b0,4'b1001,1'b0,1'b0,1'b0, 2'b00,2'b00,4'b1001,1'b1}, // R9 sticky
        {1'b0,4'b0000,2'b00,1'b0,4'b1001,1'b0,1'b0,1'b1, 2'b00,2'b00,4'b1001,1'b0}, // R9 clear
        {1'b1,4'b1011,2'b01,1'b0,4'b1001,1'b0,1'b0,1'b0, 2'b00,2'b01,4'b1011,1'b0}, // R2 request HS RC
        {1'b0,4'b0000,2'b00,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b01,2'b01,4'b1011,1'b0}, // R3 switch
        {1'b1,4'b1001,2'b01,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b01,2'b01,4'b1011,1'b0}, // R5 HS RC off refused
        {1'b1,4'b1011,2'b11,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b01,2'b11,4'b1011,1'b0}, // R2 status lags
        {1'b0,4'b0000,2'b00,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b11,2'b11,4'b1011,1'b0}, // R2 PLL active
        {1'b1,4'b1001,2'b11,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b11,2'b11,4'b1011,1'b0}, // R5 via PLL refused
        {1'b1,4'b1011,2'b00,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b11,2'b00,4'b1011,1'b0}, // R2 back to MS
        {1'b0,4'b0000,2'b00,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b00,2'b00,4'b1011,1'b0}, // R2 MS active
        {1'b1,4'b1010,2'b00,1'b0,4'b1011,1'b0,1'b0,1'b0, 2'b00,2'b00,4'b1011,1'b0}, // R6 MS off refused
        {1'b1,4'b1111,2'b10,1'b1,4'b1111,1'b0,1'b0,1'b0, 2'b00,2'b10,4'b1111,1'b0}, // R8 monitor off
        {1'b0,4'b0000,2'b00,1'b0,4'b1111,1'b0,1'b0,1'b0, 2'b10,2'b10,4'b1111,1'b0}, // R2 crystal active
        {1'b0,4'b0000,2'b00,1'b0,4'b1111,1'b1,1'b0,1'b0, 2'b10,2'b10,4'b1111,1'b0}, // R8 fail ignored
        {1'b1,4'b1111,2'b11,1'b1,4'b0111,1'b0,1'b1,1'b0, 2'b10,2'b11,4'b1111,1'b0}, // R10 pending PLL
        {1'b0,4'b0000,2'b00,1'b0,4'b0111,1'b1,1'b0,1'b0, 2'b00,2'b00,4'b1011,1'b1}, // R10 fallback cancels
        {1'b0,4'b0000,2'b00,1'b0,4'b0111,1'b1,1'b0,1'b1, 2'b00,2'b00,4'b1011,1'b0}, // R9 clear, no new fallback
        {1'b0,4'b0000,2'b00,1'b0,4'b1111,1'b0,1'b0,1'b0, 2'b00,2'b00,4'b1011,1'b0}  // R10 not resumed
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] en, input logic [1:0] src, input logic pin,
                      input logic mon, input logic [2:0] rng, input logic [3:0] mul);
        cfg_we = 1'b1; cfg_osc_en = en; cfg_src = src; cfg_pll_in = pin;
        cfg_mon_en = mon; cfg_msr_range = rng; cfg_pll_mul = mul;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 src_act", src_act, 0);
        chk("R1 src_req", src_req, 0);
        chk("R1 osc_en", osc_en, 4'b0001);
        chk("R1 fail_flag", fail_flag, 0);
        chk("R1 nmi", nmi, 0);
        chk("R1 mon_en", mon_en, 0);
        chk("R1 msr_range", msr_range, 5);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            cfg_we = v.we; cfg_osc_en = v.en; cfg_src = v.req; cfg_pll_in = v.pin;
            src_rdy = v.rdy; xtal_fail = v.xf; cfg_mon_en = v.mon; fail_clr = v.clr;
            step();
            chk($sformatf("R2/R3 row%0d src_act", i), src_act, v.e_act);
            chk($sformatf("R2/R10 row%0d src_req", i), src_req, v.e_req);
            chk($sformatf("R4/R5/R6 row%0d osc_en", i), osc_en, v.e_en);
            chk($sformatf("R8/R9 row%0d fail_flag", i), fail_flag, v.e_fail);
            chk($sformatf("R8 row%0d nmi", i), nmi, v.e_fail);
        end
        cfg_we = 1'b0; xtal_fail = 1'b0; fail_clr = 1'b0;

        // R1 reset again after activity
        rst = 1'b1; src_rdy = 4'b0001;
        step();
        rst = 1'b0;
        chk("R1 reapply src_act", src_act, 0);
        chk("R1 reapply osc_en", osc_en, 4'b0001);
        chk("R1 reapply fail_flag", fail_flag, 0);
        chk("R1 reapply range", msr_range, 5);

        // R11 range bounds
        wr(4'b0001, 2'b00, 1'b0, 1'b0, 3'd0, 4'd0);
        chk("R11 range 0", msr_range, 0);
        wr(4'b0001, 2'b00, 1'b0, 1'b0, 3'd7, 4'd0);
        chk("R11 range 7 ignored", msr_range, 0);
        wr(4'b0001, 2'b00, 1'b0, 1'b0, 3'd6, 4'd0);
        chk("R11 range 6", msr_range, 6);

        // R7 PLL settings lock while PLL drives
        src_rdy = 4'b1001;
        wr(4'b1001, 2'b11, 1'b0, 1'b0, 3'd6, 4'd3);
        chk("R7 mul accepted", pll_mul, 3);
        step();
        chk("R7 pll active", src_act, 3);
        wr(4'b1001, 2'b11, 1'b1, 1'b0, 3'd6, 4'd9);
        chk("R7 mul locked", pll_mul, 3);
        chk("R7 input locked", pll_in_sel, 0);

        // R9 fallback wins over clear in same cycle
        src_rdy = 4'b1101;
        wr(4'b1101, 2'b10, 1'b0, 1'b1, 3'd6, 4'd3);
        step();
        chk("R9 crystal active", src_act, 2);
        xtal_fail = 1'b1; fail_clr = 1'b1;
        step();
        chk("R9 flag set despite clear", fail_flag, 1);
        chk("R8 fallback source", src_act, 0);
        xtal_fail = 1'b0;
        step();
        chk("R9 cleared", fail_flag, 0);
        fail_clr = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule